// File: doc/BRIEF.md
# Pointer-Register Address Generation Unit

This unit forms data-memory effective addresses for a small 8-bit processor core. Each request carries an addressing mode, a pointer select, a 6-bit unsigned displacement and a 16-bit direct address. The unit reads the three 16-bit pointers from the six register-file bytes presented on its input. It returns the effective address one cycle later.

Pointer forms include indirect, displacement, pre-decrement and post-increment. When a mode changes the pointer, the unit also presents the updated pointer as a low byte, a high byte and the register index of the low byte. The register file writes that pair back in the same cycle that the address is issued.

A combination that the core cannot encode is rejected with an `illegal` flag. This covers displacement from the X pointer, a reserved mode code, and a pointer select outside X/Y/Z for a pointer mode. A rejected request produces no address and no write-back.

Top module: `agu_ptr_top`

## Requirements
- R1: While `rstN` is low, and at the first sample after reset, `addrValid`, `illegal` and `wbEn` are 0.
- R2: Mode code 0 (direct) issues `directAddr` unchanged over the full 16-bit range, whatever `ptrSel` holds, with `wbEn` = 0.
- R3: Mode code 1 (indirect) issues the selected pointer value unchanged, with `wbEn` = 0.
- R4: Mode code 2 (displacement) issues the Y or Z pointer plus the zero-extended `disp` (0 to 63), with `wbEn` = 0.
- R5: Mode code 3 (pre-decrement) issues the pointer minus one, and writes that same value back.
- R6: Mode code 4 (post-increment) issues the pointer unchanged, and writes back the pointer plus one.
- R7: All pointer arithmetic wraps modulo 2^16. 0x0000 decremented gives 0xFFFF, 0xFFFF incremented gives 0x0000, and a displacement sum past 0xFFFF wraps.
- R8: Displacement mode with `ptrSel` = 0 (X) sets `illegal` = 1, `addrValid` = 0 and `wbEn` = 0.
- R9: The write-back appears in the same cycle as its address. `wbLo` carries bits 7:0 and `wbHi` carries bits 15:8 of the new pointer, and a later request sees the updated pointer.
- R10: `ptrSel` 0/1/2 selects X/Y/Z. X is R27:R26, Y is R29:R28 and Z is R31:R30. `ptrRegs[8k+7:8k]` holds register 26+k. `wbRegIdx` gives the low-byte register number: 26, 28 or 30.
- R11: Results appear exactly one clock after the cycle in which `reqValid` is high. With no request, `addrValid`, `illegal` and `wbEn` stay 0.
- R12: Mode codes 5 to 7, and `ptrSel` = 3 with any pointer mode, set `illegal` = 1 with no address and no write-back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| mode | input | 3 | Addressing mode code |
| ptrSel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z |
| disp | input | 6 | Unsigned displacement |
| directAddr | input | 16 | Address for direct mode |
| ptrRegs | input | 48 | Registers 26..31, register 26 in the low byte |
| addrValid | output | 1 | Effective address valid |
| effAddr | output | 16 | Effective address |
| illegal | output | 1 | Request rejected |
| wbEn | output | 1 | Pointer write-back enable |
| wbRegIdx | output | 5 | Register number receiving `wbLo` (`wbHi` goes to the next one) |
| wbLo | output | 8 | New pointer, low byte |
| wbHi | output | 8 | New pointer, high byte |

## Verification
Direct requests with `ptrSel` set to 3 show that the direct path ignores the pointer select. Indirect reads of distinct X, Y and Z values show that each select picks the right register pair in the right byte order. Displacement runs at 0, at 63 and across 0xFFFF separate the zero-extended add from sign extension and from a carry cut off at the wrong width. Chains of post-increments and pre-decrements, run back to back, show that the write-back reaches the register file in time for the next request, and that 0x0000 and 0xFFFF wrap. Rejected combinations are sent between legal ones, so that an illegal request which still wrote back or issued an address would show up.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [2:0] {
    AM_DIRECT  = 3'd0,
    AM_IND     = 3'd1,
    AM_DISP    = 3'd2,
    AM_PREDEC  = 3'd3,
    AM_POSTINC = 3'd4
  } addrMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic issue;       // legal request: produce an address
    logic reject;      // illegal request
    logic pickDirect;  // address comes from directAddr
    logic addOffset;   // add displacement to base
    logic stepDown;    // pre-decrement
    logic stepUp;      // post-increment
    logic writePtr;    // write updated pointer back
  } aguCtrl_t;

endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
#(
  parameter int NUM_PTRS   = 3,
  parameter int SEL_W      = 2,
  parameter int DISP_FIRST = 1   // lowest pointer index allowed to take a displacement
) (
  input  logic             reqValid,
  input  logic [2:0]       mode,
  input  logic [SEL_W-1:0] ptrSel,
  output aguCtrl_t         ctrl
);

  logic selInRange;
  logic selDispOk;
  logic modeOk;
  aguCtrl_t raw;

  assign selInRange = (ptrSel < SEL_W'(NUM_PTRS));
  assign selDispOk  = selInRange && (ptrSel >= SEL_W'(DISP_FIRST));

  always_comb begin
    raw    = '0;
    modeOk = 1'b0;
    case (mode)
      AM_DIRECT: begin
        modeOk         = 1'b1;
        raw.pickDirect = 1'b1;
      end
      AM_IND: begin
        modeOk = selInRange;
      end
      AM_DISP: begin
        modeOk        = selDispOk;
        raw.addOffset = 1'b1;
      end
      AM_PREDEC: begin
        modeOk       = selInRange;
        raw.stepDown = 1'b1;
        raw.writePtr = 1'b1;
      end
      AM_POSTINC: begin
        modeOk       = selInRange;
        raw.stepUp   = 1'b1;
        raw.writePtr = 1'b1;
      end
      default: modeOk = 1'b0;
    endcase
  end

  always_comb begin
    ctrl            = '0;
    ctrl.issue      = reqValid && modeOk;
    ctrl.reject     = reqValid && !modeOk;
    ctrl.pickDirect = ctrl.issue && raw.pickDirect;
    ctrl.addOffset  = ctrl.issue && raw.addOffset;
    ctrl.stepDown   = ctrl.issue && raw.stepDown;
    ctrl.stepUp     = ctrl.issue && raw.stepUp;
    ctrl.writePtr   = ctrl.issue && raw.writePtr;
  end

endmodule

// File: rtl/agu_dp.sv
module agu_dp
  import agu_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int NUM_PTRS = 3,
  parameter int SEL_W    = 2,
  parameter int DISP_W   = 6,
  parameter int BASE_REG = 26,
  parameter int IDX_W    = 5,
  localparam int ADDR_W  = 2 * BYTE_W,
  localparam int REGS_W  = 2 * BYTE_W * NUM_PTRS
) (
  input  logic              clk,
  input  logic              rstN,
  input  aguCtrl_t          ctrl,
  input  logic [SEL_W-1:0]  ptrSel,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] directAddr,
  input  logic [REGS_W-1:0] ptrRegs,
  output logic              addrValid,
  output logic [ADDR_W-1:0] effAddr,
  output logic              illegal,
  output logic              wbEn,
  output logic [IDX_W-1:0]  wbRegIdx,
  output logic [BYTE_W-1:0] wbLo,
  output logic [BYTE_W-1:0] wbHi
);

  logic [ADDR_W-1:0] pairVal [NUM_PTRS];
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] baseDec;
  logic [ADDR_W-1:0] baseInc;
  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] nextPtr;
  logic [IDX_W-1:0]  nextIdx;

  // each pointer: even register is the low byte, the odd one above it the high byte
  for (genvar g = 0; g < NUM_PTRS; g++) begin : g_pair
    assign pairVal[g] = {ptrRegs[(2*g+1)*BYTE_W +: BYTE_W],
                         ptrRegs[(2*g)*BYTE_W   +: BYTE_W]};
  end

  always_comb begin
    base = '0;
    for (int i = 0; i < NUM_PTRS; i++) begin
      if (ptrSel == SEL_W'(i)) base = pairVal[i];
    end
  end

  assign offset  = {{(ADDR_W-DISP_W){1'b0}}, disp};
  assign baseDec = base - ADDR_W'(1);
  assign baseInc = base + ADDR_W'(1);

  always_comb begin
    if (ctrl.pickDirect)     nextAddr = directAddr;
    else if (ctrl.stepDown)  nextAddr = baseDec;
    else if (ctrl.addOffset) nextAddr = base + offset;
    else                     nextAddr = base;
  end

  assign nextPtr = ctrl.stepDown ? baseDec : baseInc;
  assign nextIdx = IDX_W'(BASE_REG) + IDX_W'({ptrSel, 1'b0});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrValid <= 1'b0;
      effAddr   <= '0;
      illegal   <= 1'b0;
      wbEn      <= 1'b0;
      wbRegIdx  <= '0;
      wbLo      <= '0;
      wbHi      <= '0;
    end else begin
      addrValid <= ctrl.issue;
      effAddr   <= ctrl.issue ? nextAddr : '0;
      illegal   <= ctrl.reject;
      wbEn      <= ctrl.writePtr;
      wbRegIdx  <= ctrl.writePtr ? nextIdx : '0;
      wbLo      <= ctrl.writePtr ? nextPtr[BYTE_W-1:0] : '0;
      wbHi      <= ctrl.writePtr ? nextPtr[ADDR_W-1:BYTE_W] : '0;
    end
  end

endmodule

// File: rtl/agu_ptr_top.sv
module agu_ptr_top
  import agu_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int NUM_PTRS = 3,
  parameter int DISP_W   = 6,
  parameter int BASE_REG = 26,
  localparam int ADDR_W  = 2 * BYTE_W,
  localparam int SEL_W   = $clog2(NUM_PTRS + 1),
  localparam int IDX_W   = $clog2(BASE_REG + 2 * NUM_PTRS),
  localparam int REGS_W  = 2 * BYTE_W * NUM_PTRS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        mode,
  input  logic [SEL_W-1:0]  ptrSel,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] directAddr,
  input  logic [REGS_W-1:0] ptrRegs,
  output logic              addrValid,
  output logic [ADDR_W-1:0] effAddr,
  output logic              illegal,
  output logic              wbEn,
  output logic [IDX_W-1:0]  wbRegIdx,
  output logic [BYTE_W-1:0] wbLo,
  output logic [BYTE_W-1:0] wbHi
);

  aguCtrl_t ctrl;

  agu_ctrl #(
    .NUM_PTRS  (NUM_PTRS),
    .SEL_W     (SEL_W),
    .DISP_FIRST(1)
  ) u_ctrl (
    .reqValid(reqValid),
    .mode    (mode),
    .ptrSel  (ptrSel),
    .ctrl    (ctrl)
  );

  agu_dp #(
    .BYTE_W  (BYTE_W),
    .NUM_PTRS(NUM_PTRS),
    .SEL_W   (SEL_W),
    .DISP_W  (DISP_W),
    .BASE_REG(BASE_REG),
    .IDX_W   (IDX_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .ptrSel    (ptrSel),
    .disp      (disp),
    .directAddr(directAddr),
    .ptrRegs   (ptrRegs),
    .addrValid (addrValid),
    .effAddr   (effAddr),
    .illegal   (illegal),
    .wbEn      (wbEn),
    .wbRegIdx  (wbRegIdx),
    .wbLo      (wbLo),
    .wbHi      (wbHi)
  );

endmodule

// File: rtl/agu_ptr_chk.sv
module agu_ptr_chk #(
  parameter int BYTE_W   = 8,
  parameter int NUM_PTRS = 3,
  parameter int DISP_W   = 6,
  parameter int BASE_REG = 26,
  localparam int ADDR_W  = 2 * BYTE_W,
  localparam int SEL_W   = $clog2(NUM_PTRS + 1),
  localparam int IDX_W   = $clog2(BASE_REG + 2 * NUM_PTRS),
  localparam int REGS_W  = 2 * BYTE_W * NUM_PTRS
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [2:0]        mode,
  input logic [SEL_W-1:0]  ptrSel,
  input logic [DISP_W-1:0] disp,
  input logic [ADDR_W-1:0] directAddr,
  input logic [REGS_W-1:0] ptrRegs,
  input logic              addrValid,
  input logic [ADDR_W-1:0] effAddr,
  input logic              illegal,
  input logic              wbEn,
  input logic [IDX_W-1:0]  wbRegIdx,
  input logic [BYTE_W-1:0] wbLo,
  input logic [BYTE_W-1:0] wbHi
);

  // R11: any result needs a request one cycle earlier
  p_result_needs_req_r11: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid || illegal) |-> $past(reqValid));

  // R9: a write-back never comes without its address
  p_wb_with_addr_r9: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> addrValid);

  // R8: a rejected request issues nothing
  p_reject_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (!addrValid && !wbEn));

  // R8: displacement on X is rejected
  p_disp_x_rejected_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mode == 3'd2 && ptrSel == '0) |=> illegal);

  // R6: post-increment writes back address plus one
  p_postinc_value_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mode == 3'd4 && ptrSel < SEL_W'(NUM_PTRS))
      |=> (wbEn && {wbHi, wbLo} == effAddr + ADDR_W'(1)));

  // R5: pre-decrement writes back the issued address
  p_predec_value_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mode == 3'd3 && ptrSel < SEL_W'(NUM_PTRS))
      |=> (wbEn && {wbHi, wbLo} == effAddr));

  // R10: write-back targets an even pointer register
  p_wb_index_r10: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> (wbRegIdx == IDX_W'(BASE_REG) || wbRegIdx == IDX_W'(BASE_REG + 2) ||
              wbRegIdx == IDX_W'(BASE_REG + 4)));

  // R2: direct issues the given address
  p_direct_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mode == 3'd0) |=> (addrValid && !wbEn && effAddr == $past(directAddr)));

endmodule

bind agu_ptr_top agu_ptr_chk #(
  .BYTE_W  (BYTE_W),
  .NUM_PTRS(NUM_PTRS),
  .DISP_W  (DISP_W),
  .BASE_REG(BASE_REG)
) u_chk (.*);

// File: tb/tb_agu_ptr_top.sv
`timescale 1ns/1ps
module tb_agu_ptr_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  ptrSel = '0;
  logic [5:0]  disp = '0;
  logic [15:0] directAddr = '0;
  logic [47:0] ptrRegs;
  logic        addrValid;
  logic [15:0] effAddr;
  logic        illegal;
  logic        wbEn;
  logic [4:0]  wbRegIdx;
  logic [7:0]  wbLo;
  logic [7:0]  wbHi;

  logic [7:0] rf [6];   // model of registers 26..31
  assign ptrRegs = {rf[5], rf[4], rf[3], rf[2], rf[1], rf[0]};

  always #2.5 clk = ~clk;

  agu_ptr_top dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .mode(mode), .ptrSel(ptrSel),
    .disp(disp), .directAddr(directAddr), .ptrRegs(ptrRegs),
    .addrValid(addrValid), .effAddr(effAddr), .illegal(illegal), .wbEn(wbEn),
    .wbRegIdx(wbRegIdx), .wbLo(wbLo), .wbHi(wbHi)
  );

  typedef struct {
    logic        av;
    logic [15:0] addr;
    logic        ill;
    logic        we;
    logic [4:0]  idx;
    logic [15:0] val;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  int   checks = 0;
  int   errors = 0;
  bit   monOn = 0;
  bit   finished = 0;

  function automatic logic [15:0] ptrOf(logic [1:0] s);
    return {rf[2*s+1], rf[2*s]};
  endfunction

  task automatic setPtr(logic [1:0] s, logic [15:0] v);
    rf[2*s]   = v[7:0];
    rf[2*s+1] = v[15:8];
  endtask

  // driver: drive one request on the falling edge and push its expectation
  task automatic req(logic [2:0] m, logic [1:0] s, logic [5:0] d, logic [15:0] a, string tag);
    exp_t e;
    logic [15:0] p;
    @(negedge clk);
    reqValid = 1'b1; mode = m; ptrSel = s; disp = d; directAddr = a;
    e.tag = tag; e.av = 1'b0; e.addr = '0; e.ill = 1'b0; e.we = 1'b0; e.idx = '0; e.val = '0;
    p = (s < 2'd3) ? ptrOf(s) : 16'h0;
    case (m)
      3'd0: begin e.av = 1'b1; e.addr = a; end
      3'd1: if (s < 2'd3) begin e.av = 1'b1; e.addr = p; end else e.ill = 1'b1;
      3'd2: if (s == 2'd1 || s == 2'd2) begin e.av = 1'b1; e.addr = p + {10'd0, d}; end
            else e.ill = 1'b1;
      3'd3: if (s < 2'd3) begin
              e.av = 1'b1; e.addr = p - 16'd1; e.we = 1'b1; e.val = p - 16'd1;
              e.idx = 5'd26 + {2'b0, s, 1'b0};
            end else e.ill = 1'b1;
      3'd4: if (s < 2'd3) begin
              e.av = 1'b1; e.addr = p; e.we = 1'b1; e.val = p + 16'd1;
              e.idx = 5'd26 + {2'b0, s, 1'b0};
            end else e.ill = 1'b1;
      default: e.ill = 1'b1;
    endcase
    expQ.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 1'b0;
    end
  endtask

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: compare results just after each rising edge and apply write-backs
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (monOn) begin
        if (expQ.size() > 0) begin
          exp_t e;
          e = expQ.pop_front();
          check(addrValid == e.av, e.tag, "addrValid", 32'(addrValid), 32'(e.av));
          check(illegal == e.ill, e.tag, "illegal", 32'(illegal), 32'(e.ill));
          check(wbEn == e.we, e.tag, "wbEn", 32'(wbEn), 32'(e.we));
          if (e.av) check(effAddr == e.addr, e.tag, "effAddr", 32'(effAddr), 32'(e.addr));
          if (e.we) begin
            check(wbRegIdx == e.idx, e.tag, "wbRegIdx", 32'(wbRegIdx), 32'(e.idx));
            check({wbHi, wbLo} == e.val, e.tag, "wbHi:wbLo", 32'({wbHi, wbLo}), 32'(e.val));
          end
        end else begin
          check(!addrValid && !illegal && !wbEn, "R11", "idle outputs",
                32'({addrValid, illegal, wbEn}), 32'd0);
        end
        if (wbEn && wbRegIdx >= 5'd26 && wbRegIdx <= 5'd30) begin
          rf[wbRegIdx - 5'd26]     = wbLo;
          rf[wbRegIdx - 5'd26 + 1] = wbHi;
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    setPtr(2'd0, 16'h1234);
    setPtr(2'd1, 16'hABCD);
    setPtr(2'd2, 16'h0F0E);
    repeat (3) @(posedge clk);
    #1;
    check(!addrValid && !illegal && !wbEn, "R1", "outputs in reset",
          32'({addrValid, illegal, wbEn}), 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check(!addrValid && !illegal && !wbEn, "R1", "outputs after reset",
          32'({addrValid, illegal, wbEn}), 32'd0);
    monOn = 1;

    // R2 direct, pointer select ignored
    req(3'd0, 2'd3, 6'd0, 16'hFFFF, "R2");
    req(3'd0, 2'd0, 6'd17, 16'h0000, "R2");
    req(3'd0, 2'd2, 6'd0, 16'h8001, "R2");
    // R3 / R10 indirect on each pair
    req(3'd1, 2'd0, 6'd5, 16'h5555, "R3");
    req(3'd1, 2'd1, 6'd0, 16'h0000, "R10");
    req(3'd1, 2'd2, 6'd0, 16'h0000, "R10");
    idle(2);
    // R4 displacement limits and R7 wrap
    req(3'd2, 2'd1, 6'd0, 16'h0, "R4");
    req(3'd2, 2'd2, 6'd63, 16'h0, "R4");
    @(negedge clk); reqValid = 1'b0;
    setPtr(2'd1, 16'hFFF0);
    req(3'd2, 2'd1, 6'd63, 16'h0, "R7");
    // R8 X with displacement
    req(3'd2, 2'd0, 6'd9, 16'h0, "R8");
    req(3'd1, 2'd0, 6'd0, 16'h0, "R8");
    // R6 / R9 back-to-back post-increments on Y
    req(3'd4, 2'd1, 6'd0, 16'h0, "R6");
    req(3'd4, 2'd1, 6'd0, 16'h0, "R9");
    req(3'd4, 2'd1, 6'd0, 16'h0, "R9");
    // R5 pre-decrements on Z
    req(3'd3, 2'd2, 6'd0, 16'h0, "R5");
    req(3'd3, 2'd2, 6'd0, 16'h0, "R9");
    @(negedge clk); reqValid = 1'b0;
    setPtr(2'd0, 16'h0000);
    setPtr(2'd2, 16'hFFFF);
    req(3'd3, 2'd0, 6'd0, 16'h0, "R7");
    req(3'd1, 2'd0, 6'd0, 16'h0, "R7");
    req(3'd4, 2'd2, 6'd0, 16'h0, "R7");
    req(3'd1, 2'd2, 6'd0, 16'h0, "R7");
    // R12 reserved modes and out-of-range select
    req(3'd5, 2'd1, 6'd0, 16'h1111, "R12");
    req(3'd7, 2'd0, 6'd0, 16'h1111, "R12");
    req(3'd4, 2'd3, 6'd0, 16'h0, "R12");
    req(3'd3, 2'd3, 6'd0, 16'h0, "R12");
    req(3'd1, 2'd2, 6'd0, 16'h0, "R12");
    req(3'd1, 2'd1, 6'd0, 16'h0, "R12");
    // R11 idle cycles stay quiet
    idle(4);
    req(3'd4, 2'd0, 6'd0, 16'h0, "R11");
    idle(3);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule